// File: doc/BRIEF.md
# PLL feedback divider ramp sequencer

This controller retunes a running PLL to a new feedback multiplier N without passing through bypass. It drives the PLL's own hardware dynamic-ramp feature, which glides the VCO from the old N to the new one. A start request carries the requested N, the N the PLL is running at, and the intermediate (post-reference-divider) frequency in kHz.

From these inputs the block picks the pair of ramp step constants for that intermediate frequency. It then raises the slowdown control, writes the new N and enables the ramp, separating these steps by microsecond waits paced by an external tick. After that it polls a synchronized ramp-complete flag once per tick, up to a bounded number of polls. Slowdown and ramp enable drop together on exit, and one done pulse reports success, timeout or an unsupported frequency.

A request that would not change N, or that names an unsupported intermediate frequency, finishes at once and leaves every PLL control output untouched.

Top module: `fbramp_seq`

## Requirements
- R1: After reset, step_load_o, slow_o, n_wr_o, ramp_en_o, done_o and busy_o are 0, n_val_o is 0 and status_o is 2'b00.
- R2: If n_new_i equals n_cur_i when start_i is sampled in idle, done_o pulses on the next cycle with status_o = 2'b00 (ok), and step_load_o, slow_o, n_wr_o, ramp_en_o and n_val_o do not change.
- R3: The intermediate frequency selects the step constants: 12000, 12800 and 13000 kHz give step A 0x2B and step B 0x0B; 19200 kHz gives 0x12 and 0x08; 38400 kHz gives 0x04 and 0x05. The values appear on step_a_o and step_b_o while step_load_o is high.
- R4: Any other ref_khz_i value ends the request on the next cycle with done_o and status_o = 2'b10 (bad reference). No ramp control output moves.
- R5: A ramp runs in this order. step_load_o pulses for one cycle, and slow_o rises on the following cycle. After WAIT_US ticks, n_wr_o pulses once with n_val_o equal to the requested N. After WAIT_US more ticks, ramp_en_o rises.
- R6: While ramp_en_o is high, the synchronized ramp-done flag is sampled once per us_tick_i. The first sample that finds it set ends the ramp with status_o = 2'b00, including the last permitted sample.
- R7: On exit, slow_o and ramp_en_o fall on the same clock edge, and done_o pulses in that same cycle.
- R8: If MAX_POLLS samples have found the flag clear, the ramp ends after the exit step with status_o = 2'b01 (timeout).
- R9: ramp_done_i passes through SYNC_STAGES (two by default) flip-flops before sampling. A level that arrives one cycle before a sampling tick is seen only at the following tick.
- R10: A start_i pulse while busy_o is high is ignored. The running ramp keeps its N, and no extra done_o pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, sampled in idle only |
| n_new_i | input | N_W | Requested feedback multiplier |
| n_cur_i | input | N_W | Multiplier the PLL currently runs at |
| ref_khz_i | input | FREQ_W | Intermediate frequency in kHz |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| ramp_done_i | input | 1 | Asynchronous ramp-complete flag from the PLL |
| step_load_o | output | 1 | Pulse: load step_a_o and step_b_o into the PLL |
| step_a_o | output | STEP_W | Ramp step constant A |
| step_b_o | output | STEP_W | Ramp step constant B |
| slow_o | output | 1 | Slowdown-using-PLL control |
| n_wr_o | output | 1 | Pulse: write n_val_o into the PLL |
| n_val_o | output | N_W | Multiplier value to write |
| ramp_en_o | output | 1 | Dynamic ramp enable |
| busy_o | output | 1 | A ramp sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 00 ok, 01 timeout, 10 bad reference |

## Verification
A wrong sequencer state shows up at once as controls in the wrong order. Examples are an N write or ramp enable outside slowdown, a missing load pulse, or slowdown and ramp enable that do not fall together, and each of these is visible in the cycle it happens. A wrong wait or poll count shows up as a tick count that differs between phase edges, observed over a few microseconds. The bench therefore counts ticks between every pair of output events. It sweeps the arrival of the done flag across every poll position, both early and late relative to the tick, to expose an off-by-one in the poll budget or a missing synchronizer stage. The early-exit paths are checked by watching that no control output moves.

// File: rtl/fbramp_pkg.sv
package fbramp_pkg;

   typedef enum logic [1:0] {
      RS_OK      = 2'b00,
      RS_TIMEOUT = 2'b01,
      RS_BADREF  = 2'b10
   } ramp_status_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_LOAD,
      SQ_SETTLE,
      SQ_PRERAMP,
      SQ_POLL
   } seq_state_e;

   typedef struct packed {
      logic       hit;
      logic [7:0] a;
      logic [7:0] b;
   } step_pair_t;

   localparam int unsigned REF_12000 = 12000;
   localparam int unsigned REF_12800 = 12800;
   localparam int unsigned REF_13000 = 13000;
   localparam int unsigned REF_19200 = 19200;
   localparam int unsigned REF_38400 = 38400;

   localparam logic [7:0] STEP_A_LOW  = 8'h2B;
   localparam logic [7:0] STEP_B_LOW  = 8'h0B;
   localparam logic [7:0] STEP_A_MID  = 8'h12;
   localparam logic [7:0] STEP_B_MID  = 8'h08;
   localparam logic [7:0] STEP_A_HIGH = 8'h04;
   localparam logic [7:0] STEP_B_HIGH = 8'h05;

endpackage

// File: rtl/fbramp_sync.sv
module fbramp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("fbramp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/fbramp_step_lut.sv
module fbramp_step_lut
   import fbramp_pkg::*;
#(
   parameter int FREQ_W = 16
) (
   input  logic [FREQ_W-1:0] ref_khz_i,
   output step_pair_t        pair_o
);

   if (FREQ_W < 16) begin : g_bad_freq_w
      $error("fbramp_step_lut: FREQ_W must hold 38400");
   end

   always_comb begin
      pair_o = '0;
      case (ref_khz_i)
         FREQ_W'(REF_12000),
         FREQ_W'(REF_12800),
         FREQ_W'(REF_13000): pair_o = '{hit: 1'b1, a: STEP_A_LOW,  b: STEP_B_LOW};
         FREQ_W'(REF_19200): pair_o = '{hit: 1'b1, a: STEP_A_MID,  b: STEP_B_MID};
         FREQ_W'(REF_38400): pair_o = '{hit: 1'b1, a: STEP_A_HIGH, b: STEP_B_HIGH};
         default:            pair_o = '0;
      endcase
   end

endmodule

// File: rtl/fbramp_tick_cnt.sv
module fbramp_tick_cnt #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic en_i,
   output logic hit_o
);

   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("fbramp_tick_cnt: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   assign hit_o = en_i && (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (clr_i || hit_o)  cnt_q <= '0;
      else if (en_i)            cnt_q <= cnt_q + 1'b1;
   end

   // R6 / R8: the poll or wait count never passes its budget
   assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < CW'(LIMIT));

endmodule

// File: rtl/fbramp_seq.sv
module fbramp_seq
   import fbramp_pkg::*;
#(
   parameter int          N_W         = 8,
   parameter int          FREQ_W      = 16,
   parameter int          STEP_W      = 8,
   parameter int unsigned WAIT_US     = 1,
   parameter int unsigned MAX_POLLS   = 500,
   parameter int          SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [N_W-1:0]    n_new_i,
   input  logic [N_W-1:0]    n_cur_i,
   input  logic [FREQ_W-1:0] ref_khz_i,
   input  logic              us_tick_i,
   input  logic              ramp_done_i,
   output logic              step_load_o,
   output logic [STEP_W-1:0] step_a_o,
   output logic [STEP_W-1:0] step_b_o,
   output logic              slow_o,
   output logic              n_wr_o,
   output logic [N_W-1:0]    n_val_o,
   output logic              ramp_en_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [1:0]        status_o
);

   if (STEP_W < 6) begin : g_bad_step_w
      $error("fbramp_seq: STEP_W must hold 0x2B");
   end
   if (N_W < 1) begin : g_bad_n_w
      $error("fbramp_seq: N_W must be positive");
   end

   seq_state_e        state_q;
   step_pair_t        pair;
   logic              done_sync;
   logic              wait_en, wait_clr, wait_hit;
   logic              poll_en, poll_clr, poll_hit;
   logic [N_W-1:0]    n_hold_q;
   logic [N_W-1:0]    n_val_q;
   logic [STEP_W-1:0] step_a_q, step_b_q;
   logic              step_load_q, slow_q, n_wr_q, ramp_q, done_q;
   ramp_status_e      status_q;

   fbramp_step_lut #(.FREQ_W(FREQ_W)) u_lut (
      .ref_khz_i (ref_khz_i),
      .pair_o    (pair)
   );

   fbramp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (ramp_done_i),
      .q_o    (done_sync)
   );

   assign wait_en  = us_tick_i && (state_q == SQ_SETTLE || state_q == SQ_PRERAMP);
   assign wait_clr = (state_q == SQ_LOAD);
   assign poll_en  = us_tick_i && (state_q == SQ_POLL);
   assign poll_clr = (state_q != SQ_POLL);

   fbramp_tick_cnt #(.LIMIT(WAIT_US)) u_wait (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (wait_clr),
      .en_i   (wait_en),
      .hit_o  (wait_hit)
   );

   fbramp_tick_cnt #(.LIMIT(MAX_POLLS)) u_poll (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (poll_clr),
      .en_i   (poll_en),
      .hit_o  (poll_hit)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= SQ_IDLE;
         n_hold_q    <= '0;
         n_val_q     <= '0;
         step_a_q    <= '0;
         step_b_q    <= '0;
         step_load_q <= 1'b0;
         slow_q      <= 1'b0;
         n_wr_q      <= 1'b0;
         ramp_q      <= 1'b0;
         done_q      <= 1'b0;
         status_q    <= RS_OK;
      end else begin
         step_load_q <= 1'b0;
         n_wr_q      <= 1'b0;
         done_q      <= 1'b0;
         case (state_q)
            SQ_IDLE: begin
               if (start_i) begin
                  if (n_new_i == n_cur_i) begin
                     done_q   <= 1'b1;
                     status_q <= RS_OK;
                  end else if (!pair.hit) begin
                     done_q   <= 1'b1;
                     status_q <= RS_BADREF;
                  end else begin
                     step_a_q    <= STEP_W'(pair.a);
                     step_b_q    <= STEP_W'(pair.b);
                     step_load_q <= 1'b1;
                     n_hold_q    <= n_new_i;
                     state_q     <= SQ_LOAD;
                  end
               end
            end
            SQ_LOAD: begin
               slow_q  <= 1'b1;
               state_q <= SQ_SETTLE;
            end
            SQ_SETTLE: begin
               if (wait_hit) begin
                  n_val_q <= n_hold_q;
                  n_wr_q  <= 1'b1;
                  state_q <= SQ_PRERAMP;
               end
            end
            SQ_PRERAMP: begin
               if (wait_hit) begin
                  ramp_q  <= 1'b1;
                  state_q <= SQ_POLL;
               end
            end
            SQ_POLL: begin
               if (poll_en && (done_sync || poll_hit)) begin
                  slow_q   <= 1'b0;
                  ramp_q   <= 1'b0;
                  done_q   <= 1'b1;
                  status_q <= done_sync ? RS_OK : RS_TIMEOUT;
                  state_q  <= SQ_IDLE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign step_load_o = step_load_q;
   assign step_a_o    = step_a_q;
   assign step_b_o    = step_b_q;
   assign slow_o      = slow_q;
   assign n_wr_o      = n_wr_q;
   assign n_val_o     = n_val_q;
   assign ramp_en_o   = ramp_q;
   assign busy_o      = (state_q != SQ_IDLE);
   assign done_o      = done_q;
   assign status_o    = status_q;

   // R5: ramp enable only under slowdown
   assert_ramp_in_slow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ramp_q |-> slow_q);

   // R5: N write happens under slowdown, before the ramp
   assert_nwr_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      n_wr_q |-> (slow_q && !ramp_q));

   // R5: slowdown rises the cycle after the step load
   assert_slow_after_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(slow_q) |-> $past(step_load_q));

   // R7: slowdown and ramp enable fall together with done
   assert_exit_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(slow_q) |-> ($fell(ramp_q) && done_q));

   // R4: a rejected reference moves no ramp control
   assert_badref_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_q && status_q == RS_BADREF) |-> (!slow_q && !ramp_q && !$past(slow_q)));

   // R8: timeout is reported only out of a running ramp
   assert_timeout_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_q && status_q == RS_TIMEOUT) |-> $past(ramp_q));

endmodule

// File: tb/fbramp_seq_tb.sv
module fbramp_seq_tb;

   localparam int WAIT_T = 2;
   localparam int POLLS  = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  n_new_i = '0, n_cur_i = '0;
   logic [15:0] ref_khz_i = '0;
   logic        ramp_done_i = 1'b0;
   logic [1:0]  div_q = '0;
   logic        us_tick;
   logic        step_load_o, slow_o, n_wr_o, ramp_en_o, busy_o, done_o;
   logic [7:0]  step_a_o, step_b_o, n_val_o;
   logic [1:0]  status_o;
   int          total = 0, fails = 0;

   always #4 clk = ~clk;

   always_ff @(posedge clk) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 2'd1;
   end
   assign us_tick = (div_q == 2'd3);

   fbramp_seq #(.N_W(8), .FREQ_W(16), .STEP_W(8), .WAIT_US(WAIT_T),
                .MAX_POLLS(POLLS), .SYNC_STAGES(2)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .n_new_i(n_new_i),
      .n_cur_i(n_cur_i), .ref_khz_i(ref_khz_i), .us_tick_i(us_tick),
      .ramp_done_i(ramp_done_i), .step_load_o(step_load_o), .step_a_o(step_a_o),
      .step_b_o(step_b_o), .slow_o(slow_o), .n_wr_o(n_wr_o), .n_val_o(n_val_o),
      .ramp_en_o(ramp_en_o), .busy_o(busy_o), .done_o(done_o), .status_o(status_o));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // {valid, step A, step B} from the requirement table
   function automatic logic [16:0] exp_steps(input logic [15:0] f);
      if (f == 16'd12000 || f == 16'd12800 || f == 16'd13000) return {1'b1, 8'h2B, 8'h0B};
      if (f == 16'd19200) return {1'b1, 8'h12, 8'h08};
      if (f == 16'd38400) return {1'b1, 8'h04, 8'h05};
      return 17'd0;
   endfunction

   task automatic run_case(input logic [7:0] nn, input logic [7:0] nc, input logic [15:0] f,
                           input int j, input bit late, input bit poke);
      logic [16:0] e;
      int   seen_load = 0, t1 = 0, t2 = 0, polls = 0, nwr_cnt = 0, done_cyc = -1, extra = 0;
      bit   raised = 0, seen_nwr = 0, got_done = 0, act = 0, ramp_prev = 0, exit_ok = 0;
      logic [7:0] la = '0, lb = '0, nv_wr = '0, nv_before;
      logic [1:0] st = '0;
      int   exp_p;
      e = exp_steps(f);
      nv_before = n_val_o;
      @(negedge clk);
      start_i = 1'b1; n_new_i = nn; n_cur_i = nc; ref_khz_i = f;
      @(negedge clk);
      start_i = 1'b0;
      for (int c = 0; c < 600 && !got_done; c++) begin
         if (c > 0) @(negedge clk);
         if (poke && c == 3) begin
            start_i = 1'b1; n_new_i = nn + 8'd9; n_cur_i = nn + 8'd9;
         end else if (poke && c == 4) start_i = 1'b0;
         if (poke && c == 3) check(busy_o == 1'b1, "R10 busy during ramp", busy_o, 1);
         if (step_load_o) begin seen_load++; la = step_a_o; lb = step_b_o; end
         if (slow_o || n_wr_o || ramp_en_o || step_load_o) act = 1;
         if (n_wr_o) begin seen_nwr = 1; nwr_cnt++; nv_wr = n_val_o; end
         if (slow_o && !seen_nwr && us_tick) t1++;
         if (seen_nwr && slow_o && !ramp_en_o && us_tick) t2++;
         if (ramp_en_o && us_tick) polls++;
         if (!raised && j > 0 && ramp_en_o && polls == j && (late ? (div_q == 2'd2) : us_tick)) begin
            raised = 1; ramp_done_i = 1'b1;
         end
         if (done_o) begin
            got_done = 1; done_cyc = c; st = status_o;
            exit_ok = !slow_o && !ramp_en_o && ramp_prev;
         end
         ramp_prev = ramp_en_o;
      end
      ramp_done_i = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (done_o) extra++;
      end
      check(got_done, "R2/R4/R6/R8 done pulse seen", got_done, 1);
      if (nn == nc) begin
         check(done_cyc == 0, "R2 immediate done cycle", done_cyc, 0);
         check(st == 2'b00, "R2 status ok", st, 0);
         check(!act, "R2 no control activity", act, 0);
         check(n_val_o == nv_before, "R2 n_val untouched", n_val_o, nv_before);
      end else if (!e[16]) begin
         check(done_cyc == 0, "R4 immediate done cycle", done_cyc, 0);
         check(st == 2'b10, "R4 bad reference status", st, 2);
         check(!act, "R4 no control activity", act, 0);
      end else begin
         check(seen_load == 1, "R5 one step load", seen_load, 1);
         check(la == e[15:8], "R3 step A", la, e[15:8]);
         check(lb == e[7:0], "R3 step B", lb, e[7:0]);
         check(t1 == WAIT_T, "R5 ticks before N write", t1, WAIT_T);
         check(t2 == WAIT_T, "R5 ticks before ramp enable", t2, WAIT_T);
         check(nwr_cnt == 1, "R5 single N write", nwr_cnt, 1);
         check(nv_wr == nn, "R5/R10 N written", nv_wr, nn);
         check(exit_ok, "R7 joint exit", exit_ok, 1);
         exp_p = (j == 0) ? POLLS + 1 : (late ? j + 2 : j + 1);
         if (exp_p <= POLLS) begin
            check(st == 2'b00, "R6 ok status", st, 0);
            check(polls == exp_p, late ? "R9 late flag polls" : "R6 polls to done", polls, exp_p);
         end else begin
            check(st == 2'b01, "R8 timeout status", st, 1);
            check(polls == POLLS, "R8 polls at timeout", polls, POLLS);
         end
         if (poke) check(extra == 0, "R10 no extra done", extra, 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check({step_load_o, slow_o, n_wr_o, ramp_en_o, done_o, busy_o} == 6'b0, "R1 controls idle",
            {step_load_o, slow_o, n_wr_o, ramp_en_o, done_o, busy_o}, 0);
      check(n_val_o == 8'd0 && status_o == 2'b00, "R1 value and status", {n_val_o, status_o}, 0);

      // R3 every table entry, ramp ends at poll 3
      run_case(8'd40, 8'd30, 16'd12000, 2, 1'b0, 1'b0);
      run_case(8'd41, 8'd30, 16'd12800, 2, 1'b0, 1'b0);
      run_case(8'd42, 8'd30, 16'd13000, 2, 1'b0, 1'b0);
      run_case(8'd43, 8'd30, 16'd19200, 2, 1'b0, 1'b0);
      run_case(8'd44, 8'd30, 16'd38400, 2, 1'b0, 1'b0);

      // R2 no change of N
      run_case(8'd77, 8'd77, 16'd19200, 1, 1'b0, 1'b0);

      // R4 unlisted references, including neighbours of listed ones
      run_case(8'd50, 8'd30, 16'd0, 1, 1'b0, 1'b0);
      run_case(8'd50, 8'd30, 16'd11999, 1, 1'b0, 1'b0);
      run_case(8'd50, 8'd30, 16'd12001, 1, 1'b0, 1'b0);
      run_case(8'd50, 8'd30, 16'd19201, 1, 1'b0, 1'b0);
      run_case(8'd50, 8'd30, 16'd38399, 1, 1'b0, 1'b0);
      run_case(8'd50, 8'd30, 16'd65535, 1, 1'b0, 1'b0);

      // R6 R8 R9 sweep of flag arrival over every poll, early and late
      run_case(8'd60, 8'd20, 16'd19200, 0, 1'b0, 1'b0);
      for (int jj = 1; jj <= POLLS + 1; jj++) begin
         run_case(8'(60 + jj), 8'd20, 16'd19200, jj, 1'b0, 1'b0);
         run_case(8'(90 + jj), 8'd20, 16'd38400, jj, 1'b1, 1'b0);
      end

      // R10 start while busy is ignored
      run_case(8'd120, 8'd100, 16'd12800, 3, 1'b0, 1'b1);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule